// File: doc/BRIEF.md
# Shared-Bus Multicycle Datapath

This block is the datapath half of a small microcoded processor. All data moves over a single 32-bit bus. Four sources can drive the bus: the memory read port, the ALU, the register file and the immediate extender. Each source has its own drive enable. Any set of the operand latches, the address latch, the instruction register and the register file can capture the bus value in the same cycle, because each has its own load strobe.

An external sequencer, which is not part of this block, drives the control points one cycle at a time. It watches the `busy`, `zero` and `opcode` outputs to decide what to do next. The register file holds 32 general registers and the program counter. Its index comes either from an instruction field or from a fixed PC or link selection.

Memory is modelled behaviourally. It is word-organised and slow: an access takes several cycles and reports `busy` while it runs. It starts with computed contents, so a program and data can be fetched without any loading port.

Top module: `bus_datapath`

## Requirements
- R1: The bus carries the value of the one enabled source. With no enable active, the bus reads 0.
- R2: `bus_conflict` is 1 in any cycle with more than one drive enable active. The bus then takes the highest-priority enabled source, in the order memory, ALU, register file, immediate.
- R3: `reg_sel` picks the register-file index as follows: 0 = IR[25:21], 1 = IR[20:16], 2 = IR[15:11], 3 = index 32 (the PC), 4 = index 31 (the link register), 5 to 7 = index 0. When `reg_wr` is 1, the selected register loads the bus at the clock edge.
- R4: Register index 0 always reads as zero, and writes to it are discarded.
- R5: Latches A, B, MA and IR each load the bus only when their own strobe (`ld_a`, `ld_b`, `ld_ma`, `ld_ir`) is 1. Otherwise they hold their value.
- R6: `imm_sel` picks the immediate as follows: 0 = IR[15:0] sign-extended, 1 = IR[15:0] zero-extended, 2 = IR[15:0] sign-extended and shifted left by 2, 3 = IR[25:0] zero-extended.
- R7: `alu_op` picks the ALU result as follows: 0 = A+B, 1 = A-B, 2 = A&B, 3 = A|B, 4 = B, 5 = jump target, 6 = A+4, 7 = A. All arithmetic wraps modulo 2^32.
- R8: The jump target is {A[31:28], B[25:0], 2'b00}.
- R9: `zero` is 1 exactly when A is 0. `opcode` equals IR[31:26].
- R10: When memory is idle, a `mem_go` pulse starts an access at word MA[7:2] and raises `busy` for MEM_LAT cycles. For a write (`mem_wr`=1), the bus value of the start cycle is stored when the access ends. For a read, the data register takes the word when the access ends, and `en_mem` drives that register onto the bus. At reset, word i holds (i*32'h9E3779B9) ^ 32'h0C1A5E37.
- R11: A `mem_go` that arrives while `busy` is 1 is ignored.
- R12: After reset, all registers and latches are 0, `busy` is 0, `zero` is 1 and the bus reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_mem | input | 1 | Memory read data drives the bus |
| en_alu | input | 1 | ALU result drives the bus |
| en_reg | input | 1 | Register-file read port drives the bus |
| en_imm | input | 1 | Immediate extender drives the bus |
| ld_a | input | 1 | Load latch A from the bus |
| ld_b | input | 1 | Load latch B from the bus |
| ld_ma | input | 1 | Load the memory address latch from the bus |
| ld_ir | input | 1 | Load the instruction register from the bus |
| reg_wr | input | 1 | Write the selected register from the bus |
| reg_sel | input | 3 | Register index source |
| imm_sel | input | 2 | Immediate format |
| alu_op | input | 3 | ALU function |
| mem_go | input | 1 | Start a memory access |
| mem_wr | input | 1 | Access kind: 1 = write, 0 = read |
| bus | output | 32 | Current bus value |
| busy | output | 1 | Memory access in progress |
| zero | output | 1 | A equals zero |
| opcode | output | 6 | IR[31:26] |
| bus_conflict | output | 1 | More than one drive enable active |

## Verification
The hardest case to reach is the end of a memory access: the cycle where `busy` is still high while a new `mem_go` arrives, or where the bus and other latches keep moving during a pending write. Nothing at the ports supplies data directly. So the stimulus first builds values from the preset memory contents, the IR fields and the ALU's A+4 function. It then runs a long stretch of random control words, with `mem_go` pulses landing at every phase of the access. A behavioural model checks the bus and all status outputs on every cycle.

// File: rtl/dp_pkg.sv
package dp_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 33;
    localparam int RIDX_W = $clog2(NREG);
    localparam int PC_IDX = 32;
    localparam int LR_IDX = 31;

    typedef enum logic [2:0] {
        RS_RS = 3'd0, RS_RT = 3'd1, RS_RD = 3'd2, RS_PC = 3'd3, RS_LR = 3'd4
    } rsel_e;

    typedef enum logic [1:0] {
        IM_SEXT = 2'd0, IM_ZEXT = 2'd1, IM_BROFF = 2'd2, IM_J26 = 2'd3
    } isel_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
        OP_PASSB = 3'd4, OP_JTGT = 3'd5, OP_INC4 = 3'd6, OP_PASSA = 3'd7
    } aop_e;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] ma;
        logic [XLEN-1:0] ir;
    } latch_t;
endpackage

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [2:0]      op,
    output logic [XLEN-1:0] y
);
    always_comb begin
        unique case (aop_e'(op))
            OP_ADD:   y = a + b;
            OP_SUB:   y = a - b;
            OP_AND:   y = a & b;
            OP_OR:    y = a | b;
            OP_PASSB: y = b;
            OP_JTGT:  y = {a[XLEN-1:XLEN-4], b[25:0], 2'b00};
            OP_INC4:  y = a + XLEN'(4);
            default:  y = a;
        endcase
    end
endmodule

// File: rtl/dp_immext.sv
module dp_immext
    import dp_pkg::*;
(
    input  logic [XLEN-1:0] ir,
    input  logic [1:0]      sel,
    output logic [XLEN-1:0] y
);
    logic [XLEN-1:0] sx;
    assign sx = {{(XLEN-16){ir[15]}}, ir[15:0]};

    always_comb begin
        unique case (isel_e'(sel))
            IM_SEXT:  y = sx;
            IM_ZEXT:  y = {{(XLEN-16){1'b0}}, ir[15:0]};
            IM_BROFF: y = {sx[XLEN-3:0], 2'b00};
            default:  y = {{(XLEN-26){1'b0}}, ir[25:0]};
        endcase
    end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile
    import dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] idx,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   rdata
);
    logic [XLEN-1:0] rf_d [NREG];
    logic [XLEN-1:0] rf_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) rf_d[i] = rf_q[i];
        if (wr_en && idx != '0 && int'(idx) < NREG) rf_d[idx] = wdata;
        rdata = (int'(idx) < NREG) ? rf_q[idx] : '0;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) rf_q[i] <= rst_n ? rf_d[i] : '0;
    end

    assert_gpr0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q[0] == '0);
endmodule

// File: rtl/dp_memory.sv
module dp_memory
    import dp_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int LAT   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            wr,
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] wdata,
    output logic            busy,
    output logic [XLEN-1:0] rdata
);
    localparam int AW = $clog2(WORDS);
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [AW-1:0]   waddr;
        logic [XLEN-1:0] wd;
        logic            wr;
        logic [XLEN-1:0] rd;
    } mst_t;

    mst_t mst_d, mst_q;
    logic [XLEN-1:0] mem_d [WORDS];
    logic [XLEN-1:0] mem_q [WORDS];

    function automatic logic [XLEN-1:0] preset(int i);
        return (XLEN'(i) * 32'h9E37_79B9) ^ 32'h0C1A_5E37;
    endfunction

    always_comb begin
        mst_d = mst_q;
        for (int i = 0; i < WORDS; i++) mem_d[i] = mem_q[i];
        if (mst_q.cnt != '0) begin
            if (mst_q.cnt == CW'(1)) begin
                if (mst_q.wr) mem_d[mst_q.waddr] = mst_q.wd;
                else          mst_d.rd = mem_q[mst_q.waddr];
            end
            mst_d.cnt = mst_q.cnt - CW'(1);
        end else if (go) begin
            mst_d.cnt   = CW'(LAT);
            mst_d.waddr = addr[AW+1:2];
            mst_d.wd    = wdata;
            mst_d.wr    = wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_q <= '0;
            for (int i = 0; i < WORDS; i++) mem_q[i] <= preset(i);
        end else begin
            mst_q <= mst_d;
            for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign busy  = (mst_q.cnt != '0);
    assign rdata = mst_q.rd;

    assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy);
    assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mst_q.waddr) && $stable(mst_q.wd)));
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
    import dp_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    parameter int MEM_LAT   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_mem,
    input  logic        en_alu,
    input  logic        en_reg,
    input  logic        en_imm,
    input  logic        ld_a,
    input  logic        ld_b,
    input  logic        ld_ma,
    input  logic        ld_ir,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [1:0]  imm_sel,
    input  logic [2:0]  alu_op,
    input  logic        mem_go,
    input  logic        mem_wr,
    output logic [31:0] bus,
    output logic        busy,
    output logic        zero,
    output logic [5:0]  opcode,
    output logic        bus_conflict
);
    latch_t lat_d, lat_q;
    logic [XLEN-1:0]   alu_y, imm_y, rf_y, mem_y;
    logic [RIDX_W-1:0] ridx;

    always_comb begin
        unique case (rsel_e'(reg_sel))
            RS_RS:   ridx = RIDX_W'(lat_q.ir[25:21]);
            RS_RT:   ridx = RIDX_W'(lat_q.ir[20:16]);
            RS_RD:   ridx = RIDX_W'(lat_q.ir[15:11]);
            RS_PC:   ridx = RIDX_W'(PC_IDX);
            RS_LR:   ridx = RIDX_W'(LR_IDX);
            default: ridx = '0;
        endcase
    end

    always_comb begin
        if (en_mem)      bus = mem_y;
        else if (en_alu) bus = alu_y;
        else if (en_reg) bus = rf_y;
        else if (en_imm) bus = imm_y;
        else             bus = '0;
        bus_conflict = ($countones({en_mem, en_alu, en_reg, en_imm}) > 1);
        lat_d = lat_q;
        if (ld_a)  lat_d.a  = bus;
        if (ld_b)  lat_d.b  = bus;
        if (ld_ma) lat_d.ma = bus;
        if (ld_ir) lat_d.ir = bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign zero   = (lat_q.a == '0);
    assign opcode = lat_q.ir[31:26];

    dp_alu u_alu (.a(lat_q.a), .b(lat_q.b), .op(alu_op), .y(alu_y));
    dp_immext u_imm (.ir(lat_q.ir), .sel(imm_sel), .y(imm_y));
    dp_regfile u_rf (.clk(clk), .rst_n(rst_n), .idx(ridx), .wr_en(reg_wr),
                     .wdata(bus), .rdata(rf_y));
    dp_memory #(.WORDS(MEM_WORDS), .LAT(MEM_LAT)) u_mem (
        .clk(clk), .rst_n(rst_n), .go(mem_go), .wr(mem_wr), .addr(lat_q.ma),
        .wdata(bus), .busy(busy), .rdata(mem_y));

    assert_a_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_a |=> $stable(lat_q.a));
    assert_ir_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ir |=> $stable(opcode));
    assert_ma_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ma |=> $stable(lat_q.ma));
endmodule

// File: tb/bus_datapath_tb.sv
module bus_datapath_tb;
    localparam int LAT = 3;
    localparam int WORDS = 64;

    logic clk = 0, rst_n = 0;
    logic en_mem = 0, en_alu = 0, en_reg = 0, en_imm = 0;
    logic ld_a = 0, ld_b = 0, ld_ma = 0, ld_ir = 0, reg_wr = 0;
    logic [2:0] reg_sel = 0, alu_op = 0;
    logic [1:0] imm_sel = 0;
    logic mem_go = 0, mem_wr = 0;
    logic [31:0] bus;
    logic busy, zero, bus_conflict;
    logic [5:0] opcode;

    int vectors = 0, fails = 0;

    bus_datapath #(.MEM_WORDS(WORDS), .MEM_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_mem(en_mem), .en_alu(en_alu),
        .en_reg(en_reg), .en_imm(en_imm), .ld_a(ld_a), .ld_b(ld_b),
        .ld_ma(ld_ma), .ld_ir(ld_ir), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .imm_sel(imm_sel), .alu_op(alu_op), .mem_go(mem_go), .mem_wr(mem_wr),
        .bus(bus), .busy(busy), .zero(zero), .opcode(opcode),
        .bus_conflict(bus_conflict));

    always #10 clk = ~clk;

    // reference state
    logic [31:0] m_rf [33];
    logic [31:0] m_mem [WORDS];
    logic [31:0] m_a, m_b, m_ma, m_ir, m_rdat, m_wd;
    int m_cnt, m_addr;
    logic m_wr;

    task automatic model_reset();
        for (int i = 0; i < 33; i++) m_rf[i] = 0;
        for (int i = 0; i < WORDS; i++) m_mem[i] = (32'(i) * 32'h9E3779B9) ^ 32'h0C1A5E37;
        m_a = 0; m_b = 0; m_ma = 0; m_ir = 0; m_rdat = 0; m_wd = 0;
        m_cnt = 0; m_addr = 0; m_wr = 0;
    endtask

    function automatic int reg_index(logic [2:0] s);
        case (s)
            3'd0: return int'(m_ir[25:21]);
            3'd1: return int'(m_ir[20:16]);
            3'd2: return int'(m_ir[15:11]);
            3'd3: return 32;
            3'd4: return 31;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] alu_ref(logic [2:0] op);
        case (op)
            3'd0: return m_a + m_b;
            3'd1: return m_a - m_b;
            3'd2: return m_a & m_b;
            3'd3: return m_a | m_b;
            3'd4: return m_b;
            3'd5: return {m_a[31:28], m_b[25:0], 2'b00};
            3'd6: return m_a + 4;
            default: return m_a;
        endcase
    endfunction

    function automatic logic [31:0] imm_ref(logic [1:0] s);
        logic [31:0] sx = {{16{m_ir[15]}}, m_ir[15:0]};
        case (s)
            2'd0: return sx;
            2'd1: return {16'h0, m_ir[15:0]};
            2'd2: return sx << 2;
            default: return {6'h0, m_ir[25:0]};
        endcase
    endfunction

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(string tag, logic [3:0] en, logic [3:0] ld, logic rw,
                        logic [2:0] rs, logic [1:0] is, logic [2:0] op,
                        logic go, logic wr);
        logic [31:0] eb;
        int idx;
        @(negedge clk);
        {en_mem, en_alu, en_reg, en_imm} = en;
        {ld_a, ld_b, ld_ma, ld_ir} = ld;
        reg_wr = rw; reg_sel = rs; imm_sel = is; alu_op = op;
        mem_go = go; mem_wr = wr;
        #1;
        idx = reg_index(rs);
        if (en[3])      eb = m_rdat;
        else if (en[2]) eb = alu_ref(op);
        else if (en[1]) eb = (idx == 0) ? 32'h0 : m_rf[idx];
        else if (en[0]) eb = imm_ref(is);
        else            eb = 0;
        cmp(tag, "bus", bus, eb);
        cmp("R2", "conflict", 32'(bus_conflict), 32'($countones(en) > 1));
        cmp("R10 R11", "busy", 32'(busy), 32'(m_cnt != 0));
        cmp("R9", "zero", 32'(zero), 32'(m_a == 0));
        cmp("R9", "opcode", 32'(opcode), 32'(m_ir[31:26]));
        @(posedge clk);
        if (m_cnt != 0) begin
            if (m_cnt == 1) begin
                if (m_wr) m_mem[m_addr] = m_wd;
                else      m_rdat = m_mem[m_addr];
            end
            m_cnt--;
        end else if (go) begin
            m_cnt = LAT; m_addr = int'(m_ma[7:2]); m_wd = eb; m_wr = wr;
        end
        if (rw && idx != 0) m_rf[idx] = eb;
        if (ld[3]) m_a = eb;
        if (ld[2]) m_b = eb;
        if (ld[1]) m_ma = eb;
        if (ld[0]) m_ir = eb;
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 4'b0, 4'b0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        idle("R12", 1);
        // read word 0 into IR (R10 then R5)
        step("R10", 4'b0000, 4'b0000, 0, 0, 0, 0, 1, 0);
        idle("R10", LAT);
        step("R5", 4'b1000, 4'b0001, 0, 0, 0, 0, 0, 0);
        for (int s = 0; s < 4; s++) step("R6", 4'b0001, 4'b0000, 0, 0, 2'(s), 0, 0, 0);
        // PC and link writes through the selector
        step("R3", 4'b0001, 4'b0000, 1, 3'd3, 2'd0, 0, 0, 0);
        step("R3", 4'b0001, 4'b0000, 1, 3'd4, 2'd3, 0, 0, 0);
        step("R3", 4'b0010, 4'b0000, 0, 3'd3, 0, 0, 0, 0);
        step("R3", 4'b0010, 4'b0000, 0, 3'd4, 0, 0, 0, 0);
        for (int s = 0; s < 3; s++) begin
            step("R3", 4'b0001, 4'b0000, 1, 3'(s), 2'd1, 0, 0, 0);
            step("R3", 4'b0010, 4'b0000, 0, 3'(s), 0, 0, 0, 0);
        end
        // register zero
        step("R4", 4'b0001, 4'b0000, 1, 3'd5, 2'd0, 0, 0, 0);
        step("R4", 4'b0010, 4'b0000, 0, 3'd5, 0, 0, 0, 0);
        // ALU functions with loaded operands
        step("R5", 4'b0001, 4'b1000, 0, 0, 2'd0, 0, 0, 0);
        step("R5", 4'b0001, 4'b0100, 0, 0, 2'd2, 0, 0, 0);
        for (int o = 0; o < 8; o++) step("R7", 4'b0100, 4'b0000, 0, 0, 0, 3'(o), 0, 0);
        step("R8", 4'b0100, 4'b0000, 0, 0, 0, 3'd5, 0, 0);
        // zero flag
        step("R9", 4'b0000, 4'b1000, 0, 0, 0, 0, 0, 0);
        step("R9", 4'b0100, 4'b1000, 0, 0, 0, 3'd6, 0, 0);
        // write then repeated starts while busy
        step("R10", 4'b0100, 4'b0010, 0, 0, 0, 3'd6, 0, 0);
        step("R10", 4'b0001, 4'b0000, 0, 0, 2'd1, 0, 1, 1);
        step("R11", 4'b0100, 4'b0000, 0, 0, 0, 0, 1, 0);
        step("R11", 4'b0010, 4'b0000, 0, 3'd3, 0, 0, 1, 0);
        step("R11", 4'b0000, 4'b0000, 0, 0, 0, 0, 1, 1);
        step("R10", 4'b0000, 4'b0000, 0, 0, 0, 0, 1, 0);
        idle("R10", LAT);
        step("R10", 4'b1000, 4'b0000, 0, 0, 0, 0, 0, 0);
        // conflicts
        step("R2", 4'b1111, 4'b0000, 0, 3'd3, 0, 3'd6, 0, 0);
        step("R2", 4'b0111, 4'b0000, 0, 3'd3, 0, 3'd6, 0, 0);
        step("R2", 4'b0011, 4'b0000, 0, 3'd3, 0, 0, 0, 0);
        // random control words
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] en;
            int pick = int'($urandom_range(0, 9));
            en = (pick < 4) ? 4'(1 << pick) : (pick == 9 ? 4'($urandom) : 4'b0);
            if (pick >= 4 && pick < 9) en = 4'(1 << (pick % 4));
            step("R1", en, 4'($urandom), 1'($urandom_range(0, 3) == 0),
                 3'($urandom), 2'($urandom), 3'($urandom),
                 1'($urandom_range(0, 2) == 0), 1'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule